// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit data effective address into a physical address by searching a hashed page table held in memory. It picks a segment register from the top nibble of the address and combines that segment's virtual segment ID with the page number to form a hash. The complement of that hash is a second hash. Each hash is masked and merged with a table origin to give the address of an eight-entry group. The walker reads each entry through a single-word memory read port, and returns a hit or miss, the physical address and a write-permission flag.

Requests arrive on a valid/ready channel. `req_ready` is high only while the walker is idle. Results leave on a second valid/ready channel, and the walker holds a result unchanged while `res_ready` is low. That back-pressure stalls the walker completely, and no new request is taken until the result has been taken. The memory read port is also valid/ready on the request side. Its responses come back on `mem_rsp_valid` in any later cycle and cannot be refused, because the walker has at most one read outstanding. The segment registers and the table origin and mask are plain level inputs. Software must hold them steady while a walk is in progress.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is chosen by EA[31:28]. Slot i of `seg_vsid` occupies bits [24*i+23:24*i]. The walker copies the chosen VSID when it accepts the request.
- R2: The primary hash is {8'b0, VSID} XOR {12'b0, EA[31:12]}. The secondary hash is the bitwise complement of the primary hash.
- R3: A group address is ((hash << 6) AND {tbl_mask, 16'hFFFF}) OR {tbl_base, 16'h0000}. The merge is a bitwise OR, including when base bits overlap mask bits and when the mask has gaps. Slot k has its upper word at group + 8k and its lower word at group + 8k + 4.
- R4: An upper word matches when V (bit 31) is 1, bits [30:7] equal the VSID, bit 6 (H) equals 0 for the primary group or 1 for the secondary group, and bits [5:0] equal EA[27:22].
- R5: Entries are tried in this order: primary slots 0 to 7, then secondary slots 0 to 7. The first match is used. The walker reads the lower word only for that matching entry.
- R6: The lower word carries the RPN in [31:12], R in bit 8 and C in bit 7. On a hit, res_pa = {RPN, EA[11:0]}.
- R7: If the chosen entry has R=1, the result is a hit. If it has R=0, the result is a miss with res_pa = 0. res_wr_ok = hit AND C. res_allowed = hit AND (not write OR C).
- R8: If none of the 16 upper words matches, the result is a miss with res_pa = 0, after exactly 16 reads.
- R9: req_ready is high only when idle. A result stays valid and unchanged until res_ready is seen high.
- R10: The walker has at most one memory read outstanding. It holds mem_rd_valid and mem_rd_addr steady until mem_rd_ready is high, and all read addresses are word aligned.
- R11: A synchronous reset makes the walker idle, drops any walk in progress, and lowers res_valid and mem_rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| seg_vsid | input | 384 | Sixteen 24-bit segment VSIDs, slot 0 in the low bits |
| tbl_base | input | 16 | Table origin, bits [31:16] of the table address |
| tbl_mask | input | 16 | Table mask, bits [31:16] of the mask |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_hit | output | 1 | Translation found with R set |
| res_wr_ok | output | 1 | Page is writable (C set) |
| res_allowed | output | 1 | Requested access type is permitted |
| res_pa | output | 32 | Physical address, 0 on a miss |

## Verification
The assertions assume a well-behaved memory port. It returns exactly one response for each accepted read, never in the same cycle as the acceptance, and never sends a response that was not requested. They also assume that `seg_vsid`, `tbl_base` and `tbl_mask` do not change during a walk. The bench memory answers every accepted read on the following cycle, clears any pending answer when reset is applied, and changes the configuration only between walks. Stalls on the memory read port and on the result channel are inserted at random to exercise the hold rules.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_DONE = 2'd3
  } walk_state_t;

  localparam int unsigned PTE_V_BIT = 31;
  localparam int unsigned PTE_R_BIT = 8;
  localparam int unsigned PTE_C_BIT = 7;
  localparam int unsigned PAGE_SH   = 12;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VSID_W = 24,
  parameter int TBL_W  = 16
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [19:0]       ea_page,
  input  logic [TBL_W-1:0]  tbl_base,
  input  logic [TBL_W-1:0]  tbl_mask,
  output logic [31:0]       grp_pri,
  output logic [31:0]       grp_sec
);
  localparam int LOW_W = 32 - TBL_W;

  logic [31:0] h_pri, h_sec, mask_full, base_full;

  always_comb begin
    h_pri     = 32'(vsid) ^ 32'(ea_page);
    h_sec     = ~h_pri;
    mask_full = {tbl_mask, {LOW_W{1'b1}}};
    base_full = {tbl_base, {LOW_W{1'b0}}};
    // Bitwise merge: overlapping base bits alias rather than carry.
    grp_pri   = ((h_pri << 6) & mask_full) | base_full;
    grp_sec   = ((h_sec << 6) & mask_full) | base_full;
  end
endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match #(
  parameter int VSID_W = 24,
  parameter int API_W  = 6
) (
  input  logic [31:0]       upper,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              sec,
  output logic              match
);
  localparam int VSID_HI = 30;
  localparam int H_BIT   = VSID_HI - VSID_W;

  assign match = upper[hpt_pkg::PTE_V_BIT]
              && (upper[VSID_HI -: VSID_W] == vsid)
              && (upper[H_BIT] == sec)
              && (upper[API_W-1:0] == api);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VSID_W    = 24,
  parameter int SEG_SEL_W = 4,
  parameter int SLOT_W    = 3,
  parameter int API_W     = 6,
  parameter int TBL_W     = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [31:0]                         req_ea,
  input  logic                                req_write,
  input  logic [(1<<SEG_SEL_W)*VSID_W-1:0]    seg_vsid,
  input  logic [TBL_W-1:0]                    tbl_base,
  input  logic [TBL_W-1:0]                    tbl_mask,
  output logic                                mem_rd_valid,
  input  logic                                mem_rd_ready,
  output logic [31:0]                         mem_rd_addr,
  input  logic                                mem_rsp_valid,
  input  logic [31:0]                         mem_rsp_data,
  output logic                                res_valid,
  input  logic                                res_ready,
  output logic                                res_hit,
  output logic                                res_wr_ok,
  output logic                                res_allowed,
  output logic [31:0]                         res_pa
);
  import hpt_pkg::*;

  localparam int NUM_SEG = 1 << SEG_SEL_W;
  localparam int IDX_W   = SLOT_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
  localparam int PAD_W   = 32 - SLOT_W - 3;

  logic [VSID_W-1:0] seg_arr [NUM_SEG];
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign seg_arr[g] = seg_vsid[g*VSID_W +: VSID_W];
  end

  walk_state_t       st;
  logic              pend;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       ea_q;
  logic              wr_q;
  logic [VSID_W-1:0] vsid_q;
  logic              hit_q, wok_q;
  logic [31:0]       pa_q;

  logic [31:0] grp_pri, grp_sec, grp_cur;
  logic        ent_match;
  logic        unused_lo;

  hpt_hash #(.VSID_W(VSID_W), .TBL_W(TBL_W)) u_hash (
    .vsid     (vsid_q),
    .ea_page  (ea_q[31:12]),
    .tbl_base (tbl_base),
    .tbl_mask (tbl_mask),
    .grp_pri  (grp_pri),
    .grp_sec  (grp_sec)
  );

  hpt_pte_match #(.VSID_W(VSID_W), .API_W(API_W)) u_match (
    .upper (mem_rsp_data),
    .vsid  (vsid_q),
    .api   (ea_q[27 -: API_W]),
    .sec   (idx[SLOT_W]),
    .match (ent_match)
  );

  assign unused_lo = ^{mem_rsp_data[11:9], mem_rsp_data[6:0]};

  assign grp_cur      = idx[SLOT_W] ? grp_sec : grp_pri;
  assign mem_rd_addr  = grp_cur | {{PAD_W{1'b0}}, idx[SLOT_W-1:0], (st == ST_LO), 2'b00};
  assign mem_rd_valid = ((st == ST_HI) || (st == ST_LO)) && !pend;
  assign req_ready    = (st == ST_IDLE);
  assign res_valid    = (st == ST_DONE);
  assign res_hit      = hit_q;
  assign res_wr_ok    = wok_q;
  assign res_allowed  = hit_q & (~wr_q | wok_q);
  assign res_pa       = pa_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pend   <= 1'b0;
      idx    <= '0;
      ea_q   <= '0;
      wr_q   <= 1'b0;
      vsid_q <= '0;
      hit_q  <= 1'b0;
      wok_q  <= 1'b0;
      pa_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          ea_q   <= req_ea;
          wr_q   <= req_write;
          vsid_q <= seg_arr[req_ea[31 -: SEG_SEL_W]];
          idx    <= '0;
          pend   <= 1'b0;
          st     <= ST_HI;
        end
        ST_HI: begin
          if (!pend && mem_rd_ready) pend <= 1'b1;
          if (pend && mem_rsp_valid) begin
            pend <= 1'b0;
            if (ent_match) begin
              st <= ST_LO;
            end else if (idx == LAST_IDX) begin
              hit_q <= 1'b0;
              wok_q <= 1'b0;
              pa_q  <= '0;
              st    <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_LO: begin
          if (!pend && mem_rd_ready) pend <= 1'b1;
          if (pend && mem_rsp_valid) begin
            pend  <= 1'b0;
            hit_q <= mem_rsp_data[PTE_R_BIT];
            wok_q <= mem_rsp_data[PTE_R_BIT] & mem_rsp_data[PTE_C_BIT];
            pa_q  <= mem_rsp_data[PTE_R_BIT] ? {mem_rsp_data[31:PAGE_SH], ea_q[PAGE_SH-1:0]} : '0;
            st    <= ST_DONE;
          end
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [11:0] req_off,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_hit,
  input logic        res_wr_ok,
  input logic [31:0] res_pa
);
  logic [11:0] cap_off;
  logic        outstanding;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_off     <= '0;
      outstanding <= 1'b0;
    end else begin
      if (req_valid && req_ready) cap_off <= req_off;
      if (mem_rd_valid && mem_rd_ready) outstanding <= 1'b1;
      else if (mem_rsp_valid) outstanding <= 1'b0;
    end
  end

  // R9
  a_r9_idle_excl: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && res_valid));
  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_hit) && $stable(res_wr_ok)));
  // R10
  a_r10_rd_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mem_rd_valid);
  a_r10_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));
  // R7
  a_r7_wr_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_wr_ok) |-> res_hit);
  // R6
  a_r6_page_offset: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (res_pa[11:0] == cap_off));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_off       (req_ea[11:0]),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_hit       (res_hit),
  .res_wr_ok     (res_wr_ok),
  .res_pa        (res_pa)
);

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam int VSID_W = 24;
  localparam int NSEG   = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]       req_ea = '0;
  logic              req_ready;
  logic [NSEG*VSID_W-1:0] seg_vsid;
  logic [15:0]       tbl_base = 16'h0002, tbl_mask = 16'h0000;
  logic              mem_rd_valid, mem_rd_ready = 1'b0;
  logic [31:0]       mem_rd_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;
  logic              res_valid, res_ready = 1'b0;
  logic              res_hit, res_wr_ok, res_allowed;
  logic [31:0]       res_pa;

  logic [VSID_W-1:0] segs [NSEG];
  logic [31:0]       mem [logic [31:0]];
  int checks = 0, errors = 0, reads = 0;
  bit bp_en = 0, done = 0;

  always_comb for (int i = 0; i < NSEG; i++) seg_vsid[i*VSID_W +: VSID_W] = segs[i];

  hpt_walker u_dut (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] grp(input logic [31:0] ea, input bit sec);
    logic [31:0] h;
    h = {8'd0, segs[ea[31:28]]} ^ (ea >> 12);
    if (sec) h = ~h;
    return ((h << 6) & {tbl_mask, 16'hFFFF}) | {tbl_base, 16'h0000};
  endfunction

  // Memory: accepts reads, answers on the next cycle.
  initial begin
    bit pend = 0;
    logic [31:0] pa;
    forever begin
      @(negedge clk);
      if (rst) begin
        pend = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
      end else begin
        mem_rsp_valid = pend;
        mem_rsp_data  = pend ? rd(pa) : 32'h0;
        pend = 0;
      end
      mem_rd_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (!rst && mem_rd_valid && mem_rd_ready) begin
        pend = 1; pa = mem_rd_addr; reads++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] ea, input bit sec, input int slot, input bit hbit,
                     input logic [VSID_W-1:0] vsid, input logic [5:0] api,
                     input logic [19:0] rpn, input bit r, input bit c);
    logic [31:0] a;
    a = grp(ea, sec) + 32'(slot * 8);
    mem[a]     = {1'b1, vsid, hbit, api};
    mem[a + 4] = {rpn, 3'b000, r, c, 7'h00};
  endtask

  task automatic put_ok(input logic [31:0] ea, input bit sec, input int slot,
                        input logic [19:0] rpn, input bit r, input bit c);
    put(ea, sec, slot, sec, segs[ea[31:28]], ea[27:22], rpn, r, c);
  endtask

  task automatic model(input logic [31:0] ea, input bit wr, output bit hit, output bit wok,
                       output bit alw, output logic [31:0] pa, output int n);
    logic [31:0] up, lo, a;
    logic [VSID_W-1:0] v;
    v = segs[ea[31:28]];
    hit = 0; wok = 0; pa = 0; n = 0;
    for (int k = 0; k < 16; k++) begin
      a  = grp(ea, k >= 8) + 32'((k % 8) * 8);
      up = rd(a); n++;
      if (up[31] && up[30:7] == v && up[6] == (k >= 8) && up[5:0] == ea[27:22]) begin
        lo = rd(a + 4); n++;
        hit = lo[8]; wok = lo[8] & lo[7];
        pa  = lo[8] ? {lo[31:12], ea[11:0]} : 32'h0;
        break;
      end
    end
    alw = hit & (!wr | wok);
  endtask

  task automatic walk(input logic [31:0] ea, input bit wr, input int hold, input string tag);
    bit e_hit, e_wok, e_alw; logic [31:0] e_pa; int e_n, cyc; bit busy_bad;
    logic [31:0] pa0;
    model(ea, wr, e_hit, e_wok, e_alw, e_pa, e_n);
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 idle ready"}, req_ready, 1);
    req_valid = 1; req_ea = ea; req_write = wr; reads = 0;
    @(negedge clk);
    req_valid = 0;
    cyc = 0; busy_bad = 0;
    while (!res_valid && cyc < 3000) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk); cyc++;
    end
    if (cyc >= 3000) begin
      check(0, {tag, " watchdog"}, cyc, 0);
      return;
    end
    check(!busy_bad, {tag, " R9 not ready while busy"}, busy_bad, 0);
    pa0 = res_pa;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(res_valid && res_pa == pa0 && !req_ready, {tag, " R9 result held"}, res_pa, pa0);
    end
    check(res_hit == e_hit, {tag, " R7 hit"}, res_hit, e_hit);
    check(res_wr_ok == e_wok, {tag, " R7 wr_ok"}, res_wr_ok, e_wok);
    check(res_allowed == e_alw, {tag, " R7 allowed"}, res_allowed, e_alw);
    check(res_pa == e_pa, {tag, " R6 pa"}, res_pa, e_pa);
    check(reads == e_n, {tag, " R5 read count"}, reads, e_n);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(res_valid == 0 && req_ready == 1, {tag, " R9 released"}, res_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < NSEG; i++) segs[i] = 24'(i * 24'h010101 + 24'h000123) & 24'hFFFBFF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1 && res_valid == 0 && mem_rd_valid == 0, "R11 reset state", {req_ready, res_valid, mem_rd_valid}, 3'b100);

    // R1 R2 R3 R4 R6: primary slot 0, R=1 C=1
    put_ok(32'h1010_1234, 0, 0, 20'h00100, 1, 1);
    walk(32'h1010_1234, 0, 0, "R6 basic read");
    walk(32'h1010_1ABC, 1, 0, "R7 basic write");

    // R7: read-only page
    mem.delete();
    put_ok(32'h1011_0008, 0, 2, 20'h00111, 1, 0);
    walk(32'h1011_0008, 1, 0, "R7 ro write");
    walk(32'h1011_0008, 0, 0, "R7 ro read");
    // R7: R=0 ends the walk as a miss
    put_ok(32'h1011_0008, 0, 1, 20'h00222, 0, 1);
    walk(32'h1011_0008, 0, 0, "R7 unreferenced");

    // R8: empty table
    mem.delete();
    walk(32'h1050_0000, 0, 0, "R8 empty miss");

    // R5: lower slot wins, primary beats secondary
    put_ok(32'h1018_0000, 0, 5, 20'h00555, 1, 1);
    put_ok(32'h1018_0000, 0, 3, 20'h00333, 1, 1);
    walk(32'h1018_0010, 0, 0, "R5 slot order");
    put_ok(32'h1019_0000, 1, 0, 20'h00900, 1, 1);
    put_ok(32'h1019_0000, 0, 7, 20'h00777, 1, 1);
    walk(32'h1019_0000, 0, 0, "R5 primary first");
    mem.delete(); put_ok(32'h1019_0000, 1, 0, 20'h00900, 1, 1);
    walk(32'h1019_0000, 0, 0, "R5 secondary fallback");

    // R4: wrong H, wrong API, wrong VSID are skipped
    mem.delete();
    put(32'h101A_0000, 0, 0, 1, segs[1], 6'h00, 20'h0AAAA, 1, 1);
    put(32'h101A_0000, 0, 1, 0, segs[1], 6'h3F, 20'h0BBBB, 1, 1);
    put(32'h101A_0000, 0, 2, 0, segs[2], 6'h00, 20'h0CCCC, 1, 1);
    walk(32'h101A_0000, 0, 0, "R4 non matching");
    put_ok(32'h101A_0000, 1, 2, 20'h0DDDD, 1, 1);
    walk(32'h101A_0000, 0, 0, "R4 secondary match");

    // R1: segment selection
    mem.delete();
    put_ok(32'h2013_0000, 0, 0, 20'h00130, 1, 1);
    walk(32'h2013_0000, 0, 0, "R1 seg2 hit");
    walk(32'h3013_0000, 0, 0, "R1 seg3 miss");

    // R3: misaligned base ORs into the masked hash
    mem.delete();
    tbl_base = 16'h0005; tbl_mask = 16'h0003;
    put_ok(32'h1040_0000, 0, 4, 20'h00230, 1, 1);
    check(grp(32'h1040_0000, 0) < 32'h0006_0000, "R3 alias setup", grp(32'h1040_0000, 0), 32'h50000);
    walk(32'h1040_0000, 0, 0, "R3 misaligned base");
    // R3: gap in the mask
    mem.delete();
    tbl_base = 16'h0008; tbl_mask = 16'h0002;
    put_ok(32'h10C0_0000, 0, 0, 20'h00280, 1, 1);
    put_ok(32'h10C0_0000, 1, 6, 20'h00290, 1, 1);
    walk(32'h10C0_0000, 0, 0, "R3 mask gap");
    walk(32'h1080_0000, 0, 0, "R3 mask gap other");
    tbl_base = 16'h0002; tbl_mask = 16'h0000;

    // R9 R10: result hold and memory back-pressure
    mem.delete();
    put_ok(32'h1020_0000, 1, 7, 20'h00200, 1, 1);
    bp_en = 1;
    walk(32'h1020_0044, 0, 4, "R10 backpressure hit");
    walk(32'h1021_0000, 1, 3, "R10 backpressure miss");
    bp_en = 0;

    // R11: reset during a walk
    @(negedge clk);
    req_valid = 1; req_ea = 32'h1021_0000; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(req_ready == 1 && res_valid == 0 && mem_rd_valid == 0, "R11 walk dropped", {req_ready, res_valid, mem_rd_valid}, 3'b100);
    walk(32'h1020_0044, 0, 0, "R11 after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule